// File: doc/BRIEF.md
# Programmable frame-sync pulse generator

This block produces a periodic frame-synchronization strobe for a serial port. It runs in a single system-clock domain and advances only on cycles where a bit-clock tick enable is high. Two down-counters drive the strobe. One is loaded from a 12-bit period field and sets the distance between frame starts. The other is loaded from an 8-bit width field and sets how long the strobe stays high. Both counters reload together at each frame start. Alongside the level output, the block raises a one-cycle frame-start marker.

Software sets the two fields, turns on the generator with a run bit, and selects frame-sync generation with a mode bit. When the external-sync mode is selected, the period counter no longer takes part. Instead, each rising edge of an external sync input (synchronized inside the block) starts a new pulse on the next tick, and the pulse width still comes from the width field. Field changes made during a frame take effect at the next frame start.

Top module: `fsync_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first tick with the generator enabled, `fsg` and `frame_start` are both 0.
- R2: In internal mode, consecutive frame starts are exactly `period_cfg` + 1 ticks apart. `period_cfg` is a 12-bit unsigned value, so the period ranges from 1 to 4096 ticks.
- R3: When `width_cfg` < `period_cfg`, `fsg` is high after exactly `width_cfg` + 1 ticks of each frame (counting the starting tick) and low after the rest. `width_cfg` is an 8-bit unsigned value.
- R4: When `width_cfg` >= `period_cfg`, `fsg` stays high for the whole frame and never drops between frames. No error is flagged.
- R5: The outputs change only on the edge that samples `tick` = 1. With `tick` = 0 and the generator enabled, `fsg` holds and `frame_start` is 0 in the next cycle.
- R6: With `run` = 0 or `fs_mode` = 0, `fsg` and `frame_start` are 0 one cycle later and ticks have no effect. After both become 1, the first tick starts a frame.
- R7: `frame_start` is high for the one cycle that follows the tick starting a frame, and every rise of `fsg` comes with `frame_start`.
- R8: When `ext_mode` = 1, `period_cfg` has no effect. A rising edge on `ext_sync` starts a frame on the first tick at least three clocks after the edge, and no frame starts without such an edge. The pulse is `width_cfg` + 1 ticks long.
- R9: `period_cfg` and `width_cfg` are sampled only at frame start, so a change made mid-frame first shapes the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Bit-clock tick enable, one system clock wide |
| run | input | 1 | Generator run bit; 0 holds the generator idle |
| fs_mode | input | 1 | 1 selects frame-sync generation by this block |
| ext_mode | input | 1 | 1 starts frames from the external sync input |
| ext_sync | input | 1 | External sync, asynchronous |
| period_cfg | input | 12 | Frame period minus one, in ticks |
| width_cfg | input | 8 | Pulse width minus one, in ticks |
| fsg | output | 1 | Frame-sync strobe level |
| frame_start | output | 1 | One-cycle marker of a frame start |

## Verification
Every result of a tick is registered, so both outputs reflect a tick one clock after the edge that samples it. The bench drives `tick` on falling edges and reads the outputs on the next falling edge, before it drives again, which pairs each observation with the tick that caused it. An external sync edge passes two synchronizer stages and a pending flag, so it becomes usable on the third edge after it is driven. The bench waits five clocks without ticks before it gives the tick that should start the frame. Period and width are measured in consumed ticks between observed frame starts, so random gaps between ticks do not move the expected counts.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
   localparam int unsigned DEF_PER_W = 12;
   localparam int unsigned DEF_WID_W = 8;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // Reasons a frame may begin in a given cycle
   typedef enum logic [1:0] {
      START_NONE = 2'd0,
      START_INT  = 2'd1,
      START_EXT  = 2'd2
   } start_src_e;
endpackage

// File: rtl/fsync_down_cnt.sv
module fsync_down_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         zero
);
   if (W < 1) begin : g_bad_width
      $error("fsync_down_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (dec && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/fsync_edge_sync.sv
module fsync_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 1) begin : g_bad_stages
      $error("fsync_edge_sync: STAGES must be at least 1");
   end

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-1:0], din};
      end
   end

   assign rise = chain[LAST] & ~chain[STAGES];
endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
   import fsync_pkg::*;
#(
   parameter int unsigned PER_W       = DEF_PER_W,
   parameter int unsigned WID_W       = DEF_WID_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   parameter bit          EXT_SYNC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             fs_mode,
   input  logic             ext_mode,
   input  logic             ext_sync,
   input  logic [PER_W-1:0] period_cfg,
   input  logic [WID_W-1:0] width_cfg,
   output logic             fsg,
   output logic             frame_start
);
   if (PER_W < 1 || PER_W > 32) begin : g_bad_per
      $error("fsync_gen: PER_W out of range");
   end
   if (WID_W < 1 || WID_W > 32) begin : g_bad_wid
      $error("fsync_gen: WID_W out of range");
   end

   logic             en;
   logic             ext_rise;
   logic             ext_pend;
   logic             armed;
   logic             per_zero;
   logic             wid_zero;
   logic [PER_W-1:0] per_cnt;
   logic [WID_W-1:0] wid_cnt;
   start_src_e       start_src;
   logic             start;

   assign en = run & fs_mode;

   // External sync edge detection, chosen at elaboration
   if (EXT_SYNC_EN) begin : g_ext
      fsync_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (ext_sync),
         .rise (ext_rise)
      );
   end else begin : g_no_ext
      assign ext_rise = 1'b0;
   end

   // Decide whether this cycle begins a frame
   always_comb begin
      start_src = START_NONE;
      if (tick && en) begin
         if (ext_mode) begin
            if (ext_pend) start_src = START_EXT;
         end else if (!armed || per_zero) begin
            start_src = START_INT;
         end
      end
   end

   assign start = (start_src != START_NONE);

   fsync_down_cnt #(.W(PER_W)) u_per (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (!en || start),
      .load_val(period_cfg),
      .dec     (tick && en && !ext_mode && !start),
      .cnt     (per_cnt),
      .zero    (per_zero)
   );

   fsync_down_cnt #(.W(WID_W)) u_wid (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (!en || start),
      .load_val(width_cfg),
      .dec     (tick && en && fsg && !start),
      .cnt     (wid_cnt),
      .zero    (wid_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (!en) begin
         armed <= 1'b0;
      end else if (start_src == START_INT) begin
         armed <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_pend <= 1'b0;
      end else if (!en || !ext_mode) begin
         ext_pend <= 1'b0;
      end else if (ext_rise) begin
         ext_pend <= 1'b1;
      end else if (start_src == START_EXT) begin
         ext_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsg         <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         frame_start <= start;
         if (!en) begin
            fsg <= 1'b0;
         end else if (start) begin
            fsg <= 1'b1;
         end else if (tick && fsg && wid_zero) begin
            fsg <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic run,
   input logic fs_mode,
   input logic fsg,
   input logic frame_start
);
   // R5: no tick, no change of level
   a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && run && fs_mode) |=> $stable(fsg));

   // R5: no tick, no frame marker
   a_r5_no_strobe_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !frame_start);

   // R6: idle generator keeps both outputs low
   a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && fs_mode) |=> (!fsg && !frame_start));

   // R7: marker only while the strobe is high
   a_r7_strobe_with_high: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> fsg);

   // R7: every rise of the strobe is a marked frame start
   a_r7_rise_marked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsg) |-> frame_start);

   // R1: outputs low while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_low: assert (!fsg && !frame_start);
      end
   end
endmodule

bind fsync_gen fsync_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .run        (run),
   .fs_mode    (fs_mode),
   .fsg        (fsg),
   .frame_start(frame_start)
);

// File: tb/sim_fsync_gen.sv
`timescale 1ns/1ps
module sim_fsync_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        run = 1'b0;
   logic        fs_mode = 1'b0;
   logic        ext_mode = 1'b0;
   logic        ext_sync = 1'b0;
   logic [11:0] period_cfg = '0;
   logic [7:0]  width_cfg = '0;
   logic        fsg;
   logic        frame_start;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fsync_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run        (run),
      .fs_mode    (fs_mode),
      .ext_mode   (ext_mode),
      .ext_sync   (ext_sync),
      .period_cfg (period_cfg),
      .width_cfg  (width_cfg),
      .fsg        (fsg),
      .frame_start(frame_start)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_high(input int p, input int w);
      return (w < p) ? w + 1 : p + 1;
   endfunction

   // Run nfr complete frames; ticks appear with density dens percent.
   // When chg is set, the fields change 3 ticks into the first frame.
   task automatic frames(input int p, input int w, input int nfr, input int dens,
                         input bit chg, input int p2, input int w2);
      int seen = 0;
      int since = 0;
      int high = 0;
      int frm_p = 0;
      int frm_w = 0;
      int guard = 0;
      bit prev = 1'b0;
      bit first_ok = 1'b1;
      period_cfg = p[11:0];
      width_cfg  = w[7:0];
      tick = 1'b0;
      run = 1'b0;
      @(negedge clk);
      run = 1'b1;
      fs_mode = 1'b1;
      ext_mode = 1'b0;
      while (seen <= nfr && guard < 20000) begin
         guard++;
         @(negedge clk);
         if (!prev && frame_start) check(1'b0, "R5 strobe without tick", 1, 0);
         if (prev) begin
            if (frame_start) begin
               if (seen > 0) begin
                  check(since == frm_p + 1, "R2 period", since, frm_p + 1);
                  check(high == exp_high(frm_p, frm_w),
                        (frm_w >= frm_p) ? "R4 width" : "R3 width",
                        high, exp_high(frm_p, frm_w));
               end
               seen++;
               since = 1;
               high = fsg ? 1 : 0;
               frm_p = int'(period_cfg);
               frm_w = int'(width_cfg);
            end else begin
               if (seen == 0) first_ok = 1'b0;
               since++;
               if (fsg) high++;
               if (chg && seen == 1 && since == 3) begin
                  period_cfg = p2[11:0];
                  width_cfg  = w2[7:0];
               end
            end
         end
         prev = ($urandom_range(0, 99) < dens);
         tick = prev;
      end
      tick = 1'b0;
      check(first_ok, "R6 first tick starts frame", first_ok, 1);
      check(seen > nfr, "R2 frames completed", seen, nfr + 1);
   endtask

   task automatic ticks_quiet(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         check(!frame_start && !fsg, req, {frame_start, fsg}, 0);
      end
      tick = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_fails++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int hi;
      void'($urandom(32'd7531));
      // R1 reset state
      repeat (3) @(negedge clk);
      check(!fsg && !frame_start, "R1 in reset", {fsg, frame_start}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!fsg && !frame_start, "R1 after reset", {fsg, frame_start}, 0);

      // Directed shapes
      frames(15, 1, 3, 100, 1'b0, 0, 0);
      frames(15, 1, 3, 40, 1'b0, 0, 0);
      frames(0, 0, 4, 100, 1'b0, 0, 0);
      frames(3, 200, 3, 70, 1'b0, 0, 0);   // R4
      frames(5, 5, 3, 100, 1'b0, 0, 0);    // R4 equal
      frames(4095, 255, 1, 100, 1'b0, 0, 0);
      // R9 mid-frame field change
      frames(9, 2, 3, 60, 1'b1, 4, 0);

      // R6 disable by run, then by mode
      run = 1'b0;
      @(negedge clk);
      check(!fsg, "R6 run low forces fsg low", fsg, 0);
      ticks_quiet(12, "R6 run low ignores ticks");
      run = 1'b1;
      fs_mode = 1'b0;
      ticks_quiet(12, "R6 mode low ignores ticks");

      // Random mix
      for (int k = 0; k < 10; k++) begin
         frames($urandom_range(0, 40), $urandom_range(0, 45), 3,
                $urandom_range(20, 100), 1'b0, 0, 0);
      end

      // R8 external sync mode
      run = 1'b0;
      @(negedge clk);
      period_cfg = 12'd0;
      width_cfg = 8'd3;
      run = 1'b1;
      fs_mode = 1'b1;
      ext_mode = 1'b1;
      ticks_quiet(20, "R8 no edge no frame");
      for (int e = 0; e < 2; e++) begin
         ext_sync = 1'b1;
         repeat (5) @(negedge clk);
         check(!fsg && !frame_start, "R5 edge waits for tick", fsg, 0);
         tick = 1'b1;
         @(negedge clk);
         check(frame_start && fsg, "R8 edge starts frame", {frame_start, fsg}, 3);
         hi = 1;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (i > 0) check(!frame_start, "R8 period ignored", frame_start, 0);
            if (fsg) hi++;
         end
         check(!frame_start, "R8 period ignored", frame_start, 0);
         check(hi == 4, "R8 pulse width", hi, 4);
         tick = 1'b0;
         ext_sync = 1'b0;
         repeat (4) @(negedge clk);
      end
      ext_mode = 1'b0;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule